// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word-address stream for a synchronous burst read out of a memory array. A start strobe captures the first address together with a burst configuration: a length code, a bit that turns wrapping off, and the latency of the first array access. From the next active clock edge onward the block presents one word address per edge, until the programmed number of words has been issued, a stop request arrives, or a new burst replaces the current one.

When wrapping is enabled, a fixed-length burst stays inside the naturally aligned block of its own length. When wrapping is disabled, or in continuous mode, the address simply counts up. The first time such a linear burst steps across a 16-word row boundary, the block may insert a single stall. During the stall it holds the address, drops the valid strobe and raises WAIT. The stall length depends on where the start address sits within its 4-word group and on the first-access latency. A static select input picks which clock edge drives all sequencing.

The address output has no back-pressure. The consumer must take every beat on the edge after the one where `addr_valid_o` is high. The only flow control is WAIT, which the block itself generates.

Top module: `brst_addr_seq`

## Requirements
- R1: While reset is applied and after it is released with no start strobe, `addr_valid_o` and `wait_o` are low.
- R2: A start strobe sampled on an active edge puts `start_addr_i` on `addr_o` with `addr_valid_o` high from that edge on. Length code, wrap-disable bit and latency are captured on that same edge. Length code 3'b001 gives 4 words, 3'b010 gives 8 words and 3'b011 gives 16 words; then valid falls.
- R3: With the wrap-disable bit at 0 and a 4, 8 or 16-word length, each next address is the current one plus one, modulo the length, inside the aligned block of that length. For example, 4 words from 6 give 6,7,4,5.
- R4: With the wrap-disable bit at 1, a fixed-length burst counts up by one across its length boundary. For example, 8 words from 5 give 5 through 12.
- R5: Length code 3'b111, and the unused codes 3'b000, 3'b100, 3'b101 and 3'b110, select continuous mode. This mode counts up by one whatever the wrap bit says, and it ends only by stop, restart or R6.
- R6: In a counting-up burst, the all-ones address is the last beat. On the next edge valid falls and no address wraps to zero.
- R7: In a counting-up burst, a stall of length N > 0 happens only at the first step whose next address has its low four bits at zero. During it `wait_o` is high for N edges, `addr_valid_o` is low, and `addr_o` keeps the last address before the boundary. On the following edge the boundary address appears with valid high. No second stall occurs in the same burst.
- R8: N depends on the start address bits [1:0] and the latency L. It is 0 for offset 0, L-3 for offset 1, L-2 for offset 2 and L-1 for offset 3, clamped at zero.
- R9: A stop request sampled on an active edge, with no start, ends the burst: valid and WAIT are low from that edge on. This holds during a stall as well.
- R10: A start strobe during a burst abandons it and restarts from the new address with the new configuration. Start takes priority over a simultaneous stop.
- R11: `edge_sel_i` = 0 makes all state change on rising clock edges, and 1 makes it change on falling edges. The select is changed only while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| edge_sel_i | input | 1 | Active edge: 0 rising, 1 falling |
| start_i | input | 1 | Burst start strobe |
| start_addr_i | input | AW | First word address of the burst |
| len_code_i | input | 3 | Burst length code |
| wrap_dis_i | input | 1 | 1 = count linearly, 0 = wrap in block |
| latency_i | input | LW | First-access latency count |
| stop_i | input | 1 | Stop request |
| addr_o | output | AW | Current word address |
| addr_valid_o | output | 1 | Address beat valid |
| wait_o | output | 1 | Row-crossing stall in progress |

## Verification
On every active edge the assertions check the local rules of the sequence. These are: the start load, the plus-one step of a counting burst, staying inside the aligned block when wrapping, entering a stall only at the last word of a row, leaving it onto a row boundary, and the effect of stop. The stall length for each start offset and latency, the single stall per burst, the burst lengths, the end of the address space and the falling-edge mode are shown only by the bench's scenarios. There, a reference model predicts each cycle's outputs.

// File: rtl/brst_pkg.sv
package brst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2
  } seq_state_e;

  localparam int ROW_BITS = 4;

  typedef struct packed {
    logic       cont;
    logic [4:0] beats;
    logic [3:0] mask;
  } len_cfg_t;

  function automatic len_cfg_t decode_len(input logic [2:0] code);
    len_cfg_t c;
    c.cont  = 1'b0;
    c.beats = 5'd0;
    c.mask  = 4'h0;
    case (code)
      3'b001:  begin c.beats = 5'd4;  c.mask = 4'h3; end
      3'b010:  begin c.beats = 5'd8;  c.mask = 4'h7; end
      3'b011:  begin c.beats = 5'd16; c.mask = 4'hF; end
      default: begin c.cont = 1'b1;   c.beats = 5'd0; c.mask = 4'h0; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/brst_edge_sel.sv
module brst_edge_sel (
  input  logic clk_i,
  input  logic edge_sel_i,
  output logic seq_clk_o
);
  // Static select: inverting the clock moves every state change to the falling edge.
  assign seq_clk_o = edge_sel_i ? ~clk_i : clk_i;
endmodule

// File: rtl/brst_len_decode.sv
module brst_len_decode
  import brst_pkg::*;
(
  input  logic [2:0] code_i,
  output len_cfg_t   cfg_o
);
  assign cfg_o = decode_len(code_i);
endmodule

// File: rtl/brst_stall_calc.sv
module brst_stall_calc #(
  parameter int LW = 4
) (
  input  logic [1:0]    offset_i,
  input  logic [LW-1:0] lat_i,
  output logic [LW-1:0] stall_o
);
  logic [LW-1:0] sub;

  // Cycles removed from the latency: offset 1 -> 3, offset 2 -> 2, offset 3 -> 1.
  assign sub = LW'(3'd4 - {1'b0, offset_i});

  always_comb begin
    if (offset_i == 2'd0)   stall_o = '0;
    else if (lat_i > sub)   stall_o = lat_i - sub;
    else                    stall_o = '0;
  end

  always_comb begin
    assert_stall_bound_R8: assert (stall_o <= lat_i)
      else $error("stall longer than latency");
  end
endmodule

// File: rtl/brst_addr_step.sv
module brst_addr_step
  import brst_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    mask_i,
  input  logic          wrap_i,
  output logic [AW-1:0] next_o,
  output logic          row_cross_o,
  output logic          at_top_o
);
  logic [AW-1:0] mask_ext;
  logic [AW-1:0] inc;

  assign mask_ext = {{(AW-4){1'b0}}, mask_i};
  assign inc      = addr_i + AW'(1);

  always_comb begin
    if (wrap_i) next_o = (addr_i & ~mask_ext) | (inc & mask_ext);
    else        next_o = inc;
  end

  assign row_cross_o = !wrap_i && (next_o[ROW_BITS-1:0] == '0);
  assign at_top_o    = &addr_i;
endmodule

// File: rtl/brst_addr_seq.sv
module brst_addr_seq
  import brst_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_sel_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [2:0]    len_code_i,
  input  logic          wrap_dis_i,
  input  logic [LW-1:0] latency_i,
  input  logic          stop_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  output logic          wait_o
);

  logic          seq_clk;
  len_cfg_t      len_cfg;
  logic [LW-1:0] stall_len_d;
  logic [AW-1:0] next_addr;
  logic          row_cross;
  logic          at_top;

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [4:0]    rem_q, rem_d;
  logic          cont_q, cont_d;
  logic          wrap_q, wrap_d;
  logic [3:0]    mask_q, mask_d;
  logic          pend_q, pend_d;
  logic [LW-1:0] slen_q, slen_d;
  logic [LW-1:0] wcnt_q, wcnt_d;
  logic          last_beat;

  brst_edge_sel u_edge (
    .clk_i      (clk_i),
    .edge_sel_i (edge_sel_i),
    .seq_clk_o  (seq_clk)
  );

  brst_len_decode u_len (
    .code_i (len_code_i),
    .cfg_o  (len_cfg)
  );

  brst_stall_calc #(.LW(LW)) u_stall (
    .offset_i (start_addr_i[1:0]),
    .lat_i    (latency_i),
    .stall_o  (stall_len_d)
  );

  brst_addr_step #(.AW(AW)) u_step (
    .addr_i      (addr_q),
    .mask_i      (mask_q),
    .wrap_i      (wrap_q),
    .next_o      (next_addr),
    .row_cross_o (row_cross),
    .at_top_o    (at_top)
  );

  // Burst is over after this beat: count exhausted, or top of space when counting up.
  assign last_beat = (!cont_q && rem_q == 5'd0) || (!wrap_q && at_top);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cont_d  = cont_q;
    wrap_d  = wrap_q;
    mask_d  = mask_q;
    pend_d  = pend_q;
    slen_d  = slen_q;
    wcnt_d  = wcnt_q;
    if (start_i) begin
      state_d = ST_RUN;
      addr_d  = start_addr_i;
      cont_d  = len_cfg.cont;
      wrap_d  = !len_cfg.cont && !wrap_dis_i;
      mask_d  = len_cfg.mask;
      rem_d   = len_cfg.beats - 5'd1;
      pend_d  = len_cfg.cont || wrap_dis_i;
      slen_d  = stall_len_d;
      wcnt_d  = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      wcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (last_beat) begin
            state_d = ST_IDLE;
          end else if (row_cross && pend_q && slen_q != '0) begin
            state_d = ST_STALL;
            wcnt_d  = slen_q;
            pend_d  = 1'b0;
          end else begin
            addr_d = next_addr;
            rem_d  = rem_q - 5'd1;
            if (row_cross) pend_d = 1'b0;
          end
        end
        ST_STALL: begin
          if (wcnt_q == LW'(1)) begin
            state_d = ST_RUN;
            addr_d  = next_addr;
            rem_d   = rem_q - 5'd1;
            wcnt_d  = '0;
          end else begin
            wcnt_d = wcnt_q - LW'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge seq_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cont_q  <= 1'b0;
      wrap_q  <= 1'b0;
      mask_q  <= '0;
      pend_q  <= 1'b0;
      slen_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cont_q  <= cont_d;
      wrap_q  <= wrap_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
      slen_q  <= slen_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = (state_q == ST_RUN);
  assign wait_o       = (state_q == ST_STALL);

  // Start loads the captured address with valid high.
  assert_start_load_R2: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    $past(start_i) |-> (addr_valid_o && addr_o == $past(start_addr_i)));

  // Wrapping burst stays in its aligned block.
  assert_wrap_block_R3: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    (addr_valid_o && $past(addr_valid_o) && !$past(start_i) && wrap_q)
      |-> ((addr_o & ~{{(AW-4){1'b0}}, mask_q}) == ($past(addr_o) & ~{{(AW-4){1'b0}}, mask_q})));

  // Counting-up burst advances by exactly one.
  assert_linear_step_R4: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    (addr_valid_o && $past(addr_valid_o) && !$past(start_i) && !wrap_q)
      |-> (addr_o == $past(addr_o) + AW'(1)));

  // Stall begins only on the last word of a row, address held.
  assert_stall_entry_R7: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    $rose(wait_o) |-> (addr_o[ROW_BITS-1:0] == '1 && $stable(addr_o)));

  // Stall ends onto a row boundary with valid high.
  assert_stall_exit_R7: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    ($fell(wait_o) && !$past(start_i) && !$past(stop_i))
      |-> (addr_valid_o && addr_o[ROW_BITS-1:0] == '0));

  // Stop without start silences both outputs.
  assert_stop_idle_R9: assert property (@(posedge seq_clk) disable iff (!rst_ni)
    ($past(stop_i) && !$past(start_i)) |-> (!addr_valid_o && !wait_o));

endmodule

// File: tb/brst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module brst_addr_seq_tb_top;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam int AMAX = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_sel = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    len_code = 3'b000;
  logic          wrap_dis = 1'b1;
  logic [LW-1:0] latency = '0;
  logic          stop = 1'b0;
  logic [AW-1:0] addr;
  logic          valid;
  logic          waitx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_state = 0;  // 0 idle 1 run 2 stall
  int m_addr = 0, m_rem = 0, m_blk = 0, m_n = 0, m_wcnt = 0;
  bit m_cont = 0, m_wrap = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  brst_addr_seq #(.AW(AW), .LW(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .edge_sel_i(edge_sel), .start_i(start),
    .start_addr_i(start_addr), .len_code_i(len_code), .wrap_dis_i(wrap_dis),
    .latency_i(latency), .stop_i(stop), .addr_o(addr), .addr_valid_o(valid),
    .wait_o(waitx)
  );

  function automatic int stall_for(int off, int lat);
    int v;
    if (off == 0) v = 0;
    else if (off == 3) v = lat - 1;
    else if (off == 2) v = lat - 2;
    else v = lat - 3;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic model_step();
    int nxt;
    if (start) begin
      m_state = 1;
      m_addr  = int'(start_addr);
      m_cont  = !(len_code == 3'b001 || len_code == 3'b010 || len_code == 3'b011);
      m_blk   = (len_code == 3'b001) ? 4 : (len_code == 3'b010) ? 8 : 16;
      m_rem   = m_blk - 1;
      m_wrap  = !m_cont && !wrap_dis;
      m_pend  = !m_wrap;
      m_n     = stall_for(int'(start_addr) % 4, int'(latency));
    end else if (stop) begin
      m_state = 0;
    end else if (m_state == 1) begin
      if ((!m_cont && m_rem == 0) || (!m_wrap && m_addr == AMAX)) m_state = 0;
      else begin
        if (m_wrap) nxt = (m_addr / m_blk) * m_blk + ((m_addr % m_blk) + 1) % m_blk;
        else nxt = m_addr + 1;
        if (!m_wrap && nxt % 16 == 0 && m_pend && m_n > 0) begin
          m_state = 2; m_wcnt = m_n; m_pend = 0;
        end else begin
          if (!m_wrap && nxt % 16 == 0) m_pend = 0;
          m_addr = nxt; m_rem = m_rem - 1;
        end
      end
    end else if (m_state == 2) begin
      if (m_wcnt == 1) begin
        m_state = 1; m_addr = m_addr + 1; m_rem = m_rem - 1;
      end else m_wcnt = m_wcnt - 1;
    end
  endtask

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check_bit("valid", valid, m_state == 1);
    check_bit("wait", waitx, m_state == 2);
    if (m_state != 0) begin
      checks++;
      if (int'(addr) != m_addr) begin
        errors++;
        $display("FAIL %s addr: actual=%0h expected=%0h at %0t", tag, addr, m_addr, $time);
      end
    end
  endtask

  task automatic tick();
    if (edge_sel) @(negedge clk); else @(posedge clk);
    #1;
    model_step();
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic burst(string t, int a, logic [2:0] code, logic wd, int lat, int n);
    tag = t;
    start = 1'b1; start_addr = AW'(a); len_code = code; wrap_dis = wd; latency = LW'(lat);
    tick();
    start = 1'b0;
    run(n);
  endtask

  task automatic do_reset(logic es);
    rst_n = 1'b0;
    edge_sel = es;
    m_state = 0;
    #12;
    tag = "R1";
    check_bit("valid in reset", valid, 1'b0);
    check_bit("wait in reset", waitx, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    run(3);
  endtask

  initial begin
    do_reset(1'b0);
    burst("R3", 6, 3'b001, 1'b0, 4, 6);        // 6,7,4,5
    burst("R3", 13, 3'b010, 1'b0, 4, 10);      // 13,14,15,8..12
    burst("R3", 5, 3'b011, 1'b0, 9, 18);       // wraps in 0..15, no stall
    burst("R4", 5, 3'b010, 1'b1, 4, 10);       // 5..12
    burst("R2", 32, 3'b001, 1'b1, 4, 6);       // 4 beats, aligned
    burst("R7", 3, 3'b011, 1'b1, 5, 24);       // offset 3 -> 4 stall cycles
    burst("R8", 'h11, 3'b011, 1'b1, 6, 22);    // offset 1 -> 3
    burst("R8", 'h22, 3'b011, 1'b1, 2, 18);    // offset 2 -> 0
    burst("R8", 'h21, 3'b011, 1'b1, 2, 18);    // offset 1 clamped -> 0
    burst("R8", 'h1C, 3'b010, 1'b1, 7, 10);    // offset 0 -> 0
    burst("R8", 'h0E, 3'b011, 1'b1, 6, 22);    // offset 2 -> 4
    burst("R5", 'h0E, 3'b111, 1'b0, 4, 40);    // continuous, one stall only
    tag = "R9"; stop = 1'b1; tick(); stop = 1'b0; run(3);
    burst("R5", 'h30, 3'b100, 1'b0, 4, 20);    // reserved code -> continuous
    tag = "R9"; stop = 1'b1; tick(); stop = 1'b0; run(2);
    burst("R6", 'hFFFC, 3'b111, 1'b0, 4, 8);   // ends after all-ones
    burst("R6", 'hFFFA, 3'b011, 1'b1, 3, 10);
    burst("R10", 'h40, 3'b011, 1'b1, 4, 3);
    tag = "R10"; stop = 1'b1;
    burst("R10", 'h82, 3'b001, 1'b0, 4, 6);    // start beats stop
    stop = 1'b0;
    burst("R9", 'h0F, 3'b011, 1'b1, 8, 2);     // in stall now
    tag = "R9"; stop = 1'b1; tick(); stop = 1'b0; run(4);
    do_reset(1'b1);
    burst("R11", 'h07, 3'b011, 1'b1, 4, 22);   // falling-edge mode, stall 3
    burst("R11", 'h25, 3'b001, 1'b0, 4, 6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule